// File: doc/BRIEF.md
# Serial Receiver with Four-Entry Character FIFO

This block turns an asynchronous serial line into bytes. The line carries fixed frames: a low start bit, eight data bits sent least significant bit first, no parity, and a high stop bit. A strobe from outside the block marks time at four ticks per bit. The line first passes through a two-flop synchronizer. A falling edge on the synchronized line starts a frame. Each bit is then sampled once, on the second of its four ticks.

Finished characters go into a four-entry FIFO. The host reads the FIFO through a valid/ready port. `rd_valid` is high whenever at least one character is held. `rd_data` always shows the oldest character. That character is removed on any clock edge where both `rd_valid` and `rd_ready` are high. While the host holds `rd_ready` low, the head entry and `rd_valid` stay put, so the back-pressure is lossless. The receiver itself cannot be stalled.

Three level flags report how full the FIFO is. Two sticky error flags report frame and overrun errors, and each has its own clear strobe.

Top module: `serial_rx_fifo`

## Requirements
- R1: Each received frame yields the byte whose bit 0 was the first data bit on the line, presented on `rd_data` once it reaches the FIFO head.
- R2: A falling edge on the synchronized line starts a frame only if the line is still low at the second tick after the edge; a shorter low pulse is discarded and stores nothing.
- R3: Each data bit and the stop bit are sampled once, on the second of the four ticks in that bit; a line driven for exactly four tick periods per bit is received correctly at every tick phase.
- R4: The FIFO holds up to four characters and returns them in arrival order.
- R5: `lvl_empty` is high when 0 characters are held, `lvl_one_left` when exactly 3 are held, and `lvl_full` when 4 are held; at most one of the three is high.
- R6: `rd_valid` is high exactly when the FIFO is not empty. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold. `rd_ready` while empty has no effect.
- R7: A stop bit sampled low sets `frame_err`; the character is still stored.
- R8: A character that completes while four are held, with no pop in that cycle, is discarded, leaves the held characters unchanged, and sets `overrun_err`.
- R9: Each error flag stays set until its clear strobe is high on a clock edge; a set and a clear of the same flag in the same cycle leave it set.
- R10: A character that completes in the same cycle as a pop is stored and the oldest one leaves, so the count is unchanged; this holds even when four are held, and then no overrun is flagged.
- R11: After reset the FIFO is empty, `rd_valid` is low and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| sample_tick | input | 1 | One-cycle strobe at four times the bit rate |
| rd_ready | input | 1 | Host accepts the head character |
| rd_valid | output | 1 | FIFO holds at least one character |
| rd_data | output | 8 | Oldest held character |
| clr_frame_err | input | 1 | Clears `frame_err` |
| clr_overrun_err | input | 1 | Clears `overrun_err` |
| lvl_empty | output | 1 | No characters held |
| lvl_one_left | output | 1 | Exactly three characters held |
| lvl_full | output | 1 | Four characters held |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |
| overrun_err | output | 1 | Sticky: a character was dropped on a full FIFO |

## Verification
Two things can land on the same clock edge: a finished character being pushed, and a host pop or an error clear. The bench first sends one reference frame into an empty FIFO. It measures how many cycles pass from the start bit until `rd_valid` rises. Later frames are sent at the same tick phase. The bench then raises `rd_ready` or `clr_overrun_err` for exactly the cycle whose edge pushes the character.

The outcome is judged only at the ports, from three things: the level flags afterwards, the order of the characters read out, and whether `overrun_err` is set. This covers both a partly filled FIFO and a full one.

// File: rtl/urx_pkg.sv
package urx_pkg;

  // Frame receive phases
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // Index of each sticky error in the flag vector
  localparam int ERR_FRAME   = 0;
  localparam int ERR_OVERRUN = 1;
  localparam int ERR_COUNT   = 2;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/urx_deser.sv
module urx_deser
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              tick,
  output logic              char_vld,
  output logic [DATA_W-1:0] char_data,
  output logic              char_ferr
);

  localparam int PH_W  = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  PH_SAMP = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

  rx_state_t         st;
  logic [PH_W-1:0]   ph;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              line_q;

  wire at_samp = tick && (ph == PH_SAMP);
  wire at_last = tick && (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      ph        <= '0;
      idx       <= '0;
      shreg     <= '0;
      line_q    <= 1'b1;
      char_vld  <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      line_q   <= line_s;
      char_vld <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (line_q && !line_s) begin
            st <= RX_START;
            ph <= '0;
          end
        end
        RX_START: begin
          if (tick) ph <= ph + 1'b1;
          if (at_samp && line_s) begin
            st <= RX_IDLE;            // line went back high: false start
          end else if (at_last) begin
            st  <= RX_DATA;
            idx <= '0;
          end
        end
        RX_DATA: begin
          if (tick) ph <= ph + 1'b1;
          if (at_samp) shreg <= {line_s, shreg[DATA_W-1:1]};
          if (at_last) begin
            if (idx == IDX_END) st <= RX_STOP;
            else                idx <= idx + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_samp) begin
            char_vld  <= 1'b1;
            char_ferr <= !line_s;
            st        <= RX_IDLE;
          end else if (tick) begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign char_data = shreg;

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              one_left,
  output logic              full,
  output logic              drop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              pop_fire, push_fire;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CNT_W'(DEPTH));
  assign one_left = (cnt == CNT_W'(DEPTH - 1));

  assign pop_fire  = pop && !empty;
  assign push_fire = push && (!full || pop_fire);
  assign drop      = push && !push_fire;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_fire) wr_ptr <= nxt(wr_ptr);
      if (pop_fire)  rd_ptr <= nxt(rd_ptr);
      unique case ({push_fire, pop_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/urx_errflags.sv
module urx_errflags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[g] <= 1'b0;
      else if (set[g]) flag[g] <= 1'b1;   // set has priority over clear
      else if (clr[g]) flag[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int OSR    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              sample_tick,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clr_frame_err,
  input  logic              clr_overrun_err,
  output logic              lvl_empty,
  output logic              lvl_one_left,
  output logic              lvl_full,
  output logic              frame_err,
  output logic              overrun_err
);

  logic              line_s;
  logic              char_vld, char_ferr, drop;
  logic [DATA_W-1:0] char_data;
  logic [ERR_COUNT-1:0] err_set, err_clr, err_q;

  urx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_in), .q_sync(line_s)
  );

  urx_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .tick(sample_tick),
    .char_vld(char_vld), .char_data(char_data), .char_ferr(char_ferr)
  );

  urx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(char_vld), .push_data(char_data), .pop(rd_ready),
    .head(rd_data), .empty(lvl_empty), .one_left(lvl_one_left),
    .full(lvl_full), .drop(drop)
  );

  assign err_set[ERR_FRAME]   = char_vld && char_ferr;
  assign err_set[ERR_OVERRUN] = drop;
  assign err_clr[ERR_FRAME]   = clr_frame_err;
  assign err_clr[ERR_OVERRUN] = clr_overrun_err;

  urx_errflags #(.N(ERR_COUNT)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .flag(err_q)
  );

  assign rd_valid    = !lvl_empty;
  assign frame_err   = err_q[ERR_FRAME];
  assign overrun_err = err_q[ERR_OVERRUN];

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              clr_frame_err,
  input logic              clr_overrun_err,
  input logic              lvl_empty,
  input logic              lvl_one_left,
  input logic              lvl_full,
  input logic              frame_err,
  input logic              overrun_err
);

  // R5: the three levels never overlap
  a_r5_levels_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lvl_empty, lvl_one_left, lvl_full}));

  // R6: head is held under back-pressure
  a_r6_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R4: a full FIFO stays full without a pop
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_full && !rd_ready |=> lvl_full);

  // R8: overrun only rises from a full FIFO
  a_r8_overrun_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(lvl_full));

  // R9: frame error is sticky without its clear
  a_r9_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !clr_frame_err |=> frame_err);

  // R9: overrun error is sticky without its clear
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err && !clr_overrun_err |=> overrun_err);

endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .rd_data(rd_data), .clr_frame_err(clr_frame_err),
  .clr_overrun_err(clr_overrun_err), .lvl_empty(lvl_empty),
  .lvl_one_left(lvl_one_left), .lvl_full(lvl_full),
  .frame_err(frame_err), .overrun_err(overrun_err)
);

// File: tb/sim_serial_rx_fifo.sv
module sim_serial_rx_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       sample_tick = 1'b0;
  logic       rd_ready = 1'b0;
  logic       clr_frame_err = 1'b0;
  logic       clr_overrun_err = 1'b0;
  logic       rd_valid, lvl_empty, lvl_one_left, lvl_full, frame_err, overrun_err;
  logic [7:0] rd_data;

  logic [1:0] tc = 2'd0;
  int         total = 0;
  int         bad = 0;
  int         push_ofs = 0;
  event       fstart;

  always #4 clk = ~clk;   // 125 MHz

  serial_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .sample_tick(sample_tick),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .clr_frame_err(clr_frame_err), .clr_overrun_err(clr_overrun_err),
    .lvl_empty(lvl_empty), .lvl_one_left(lvl_one_left), .lvl_full(lvl_full),
    .frame_err(frame_err), .overrun_err(overrun_err)
  );

  // tick every fourth clock, updated between edges
  initial forever begin
    @(posedge clk); #2;
    tc = tc + 2'd1;
    sample_tick = (tc == 2'd3);
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic levels(input string req, input int n);
    check(req, "lvl_empty",    lvl_empty,    n == 0);
    check(req, "lvl_one_left", lvl_one_left, n == 3);
    check(req, "lvl_full",     lvl_full,     n == 4);
    check(req, "rd_valid",     rd_valid,     n != 0);
  endtask

  // 16 clocks per bit = four ticks; start aligned to a fixed tick phase
  task automatic send_frame(input logic [7:0] d, input logic stop_b);
    do @(negedge clk); while (tc != 2'd1);
    rx_in = 1'b0;
    -> fstart;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = d[i];
      repeat (16) @(negedge clk);
    end
    rx_in = stop_b;
    repeat (16) @(negedge clk);
    rx_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    check(req, "rd_valid", rd_valid, 1);
    check(req, "rd_data", rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // frame with a one-cycle strobe on the edge that pushes it
  task automatic send_strobed(input logic [7:0] d, input logic do_pop,
                              input logic do_clr);
    fork
      send_frame(d, 1'b1);
      begin
        @(fstart);
        repeat (push_ofs - 1) @(negedge clk);
        rd_ready = do_pop;
        clr_overrun_err = do_clr;
        @(negedge clk);
        rd_ready = 1'b0;
        clr_overrun_err = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: reset state
    levels("R11", 0);
    check("R11", "frame_err", frame_err, 0);
    check("R11", "overrun_err", overrun_err, 0);

    // R6: rd_ready while empty has no effect
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rd_ready = 1'b0;
    levels("R6", 0);

    // R2: short low pulse is rejected
    do @(negedge clk); while (tc != 2'd1);
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    rx_in = 1'b1;
    repeat (200) @(negedge clk);
    levels("R2", 0);
    check("R2", "frame_err", frame_err, 0);

    // R1 / R3: every byte value, LSB first
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b1);
      pop_chk("R1", 8'(v));
      if (v == 255) levels("R3", 0);
    end

    // R4 / R5 / R6: fill, watch levels and held head
    for (int k = 0; k < 4; k++) begin
      send_frame(8'hA0 + 8'(k), 1'b1);
      levels("R5", k + 1);
      check("R6", "head held", rd_data, 8'hA0);
    end

    // R8: overrun discards and preserves
    send_frame(8'h55, 1'b1);
    check("R8", "overrun_err", overrun_err, 1);
    levels("R8", 4);
    for (int k = 0; k < 4; k++) pop_chk("R4", 8'hA0 + 8'(k));
    levels("R8", 0);

    // R9: sticky until cleared
    repeat (20) @(negedge clk);
    check("R9", "overrun sticky", overrun_err, 1);
    clr_overrun_err = 1'b1;
    @(negedge clk);
    clr_overrun_err = 1'b0;
    check("R9", "overrun cleared", overrun_err, 0);

    // R7: bad stop bit flags and still stores
    send_frame(8'h3C, 1'b0);
    check("R7", "frame_err", frame_err, 1);
    pop_chk("R7", 8'h3C);
    check("R9", "frame sticky", frame_err, 1);
    clr_frame_err = 1'b1;
    @(negedge clk);
    clr_frame_err = 1'b0;
    check("R9", "frame cleared", frame_err, 0);

    // measure the push cycle offset from the start bit
    fork
      send_frame(8'h11, 1'b1);
      begin
        int k;
        @(fstart);
        k = 0;
        do begin @(negedge clk); k++; end while (!rd_valid);
        push_ofs = k;
      end
    join
    pop_chk("R1", 8'h11);

    // R10: push and pop together at three held
    for (int k = 0; k < 3; k++) send_frame(8'hB0 + 8'(k), 1'b1);
    send_strobed(8'hB3, 1'b1, 1'b0);
    levels("R10", 3);
    for (int k = 1; k < 4; k++) pop_chk("R10", 8'hB0 + 8'(k));

    // R10: push and pop together when full, no overrun
    for (int k = 0; k < 4; k++) send_frame(8'hC0 + 8'(k), 1'b1);
    send_strobed(8'hC4, 1'b1, 1'b0);
    levels("R10", 4);
    check("R10", "overrun_err", overrun_err, 0);
    for (int k = 1; k < 5; k++) pop_chk("R10", 8'hC0 + 8'(k));

    // R9: overrun set and clear in the same cycle, set wins
    for (int k = 0; k < 4; k++) send_frame(8'hD0 + 8'(k), 1'b1);
    send_strobed(8'hD4, 1'b0, 1'b1);
    check("R9", "set beats clear", overrun_err, 1);
    for (int k = 0; k < 4; k++) pop_chk("R8", 8'hD0 + 8'(k));
    levels("R4", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule